// File: doc/BRIEF.md
# Single/Double-Length Scalar Shifter

This block is a pipelined logical shifter for 64-bit scalar words. A single-length shift takes one operand and moves it left or right by an unsigned 7-bit count. Vacated positions fill with zeros. A double-length shift joins two operands into one 128-bit value, with operand A as the upper half and operand B as the lower half. It shifts that value and returns one 64-bit half. No overflow or lost-bit indication is ever produced.

The two kinds of operation share one unit and have different fixed latencies. A single-length result appears two cycles after issue and a double-length result three cycles after issue. Issue uses a valid/ready handshake. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only when the offered operation would reach the output in the same cycle as the double-length operation accepted one cycle earlier. `in_ready` may depend on `in_double` within the same cycle. A refused operation is dropped, and the source must hold or re-offer it. The result side has no back-pressure: `out_valid` pulses for exactly one cycle per accepted operation, and the sink must take it.

Top module: `dual_len_shifter`

## Requirements
- R1: A single-length left shift (`in_double`=0, `in_left`=1) yields `in_opa` shifted left by `in_count`, zero-filled. It yields 0 when `in_count` >= 64. `in_opb` has no effect. The result is valid two cycles after acceptance.
- R2: A single-length right shift (`in_double`=0, `in_left`=0) yields `in_opa` shifted right by `in_count`, zero-filled. It yields 0 when `in_count` >= 64. `in_opb` has no effect. The result is valid two cycles after acceptance.
- R3: A double-length left shift (`in_double`=1, `in_left`=1) yields bits 127..64 of the 128-bit value {`in_opa`,`in_opb`} shifted left by `in_count`, zero-filled. The result is valid three cycles after acceptance.
- R4: A double-length right shift (`in_double`=1, `in_left`=0) yields bits 63..0 of {`in_opa`,`in_opb`} shifted right by `in_count`, zero-filled. The result is valid three cycles after acceptance.
- R5: A count of zero passes an operand unchanged. Single-length shifts and double-length left shifts return `in_opa`. A double-length right shift returns `in_opb`.
- R6: `in_ready` is low exactly when a double-length operation was accepted in the previous cycle and `in_double` is 0. An operation offered while `in_ready` is low produces no result.
- R7: `out_valid` is high in exactly those cycles that are two cycles after an accepted single-length operation or three cycles after an accepted double-length operation. Results therefore never collide and leave in issue order.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_double | input | 1 | 1 = double-length, 0 = single-length |
| in_left | input | 1 | 1 = shift left, 0 = shift right |
| in_opa | input | 64 | Operand A (upper half of a double-length value) |
| in_opb | input | 64 | Operand B (lower half of a double-length value) |
| in_count | input | 7 | Unsigned shift count |
| out_valid | output | 1 | Result valid, one cycle per operation |
| out_result | output | 64 | Shift result |

## Verification
The bench keeps a reference model indexed by cycle. When an operation is accepted, the model computes its result with plain 128-bit shifts and books it for the cycle two cycles later (single-length) or three cycles later (double-length). On every cycle the bench compares `out_valid` and `out_result` with that booking, so an early, late, missing or extra result shows up as a miscompare. The bench also predicts `in_ready` from the kind of the previous accepted operation and the kind now offered, and checks it before the clock edge that would accept the operation.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic {OP_SINGLE = 1'b0, OP_DOUBLE = 1'b1} shf_len_e;
  typedef enum logic {DIR_RIGHT = 1'b0, DIR_LEFT = 1'b1} shf_dir_e;
endpackage

// File: rtl/shf_barrel.sv
// Logarithmic shifter: stage k moves the word by 2**(BASE+k) when amt[k] is set.
module shf_barrel #(
  parameter int W    = 64,
  parameter int NB   = 6,
  parameter int BASE = 0
) (
  input  logic [W-1:0]  din,
  input  logic          left,
  input  logic [NB-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:NB];

  assign stg[0] = din;

  for (genvar k = 0; k < NB; k++) begin : g_stage
    localparam int SH = 2 ** (BASE + k);
    if (SH >= W) begin : g_flush
      assign stg[k+1] = amt[k] ? '0 : stg[k];
    end else begin : g_move
      assign stg[k+1] = !amt[k] ? stg[k] :
                        (left ? (stg[k] << SH) : (stg[k] >> SH));
    end
  end

  assign dout = stg[NB];
endmodule

// File: rtl/shf_issue_ctl.sv
// Handshake and first pipeline register shared by both operation lengths.
module shf_issue_ctl #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_double,
  input  logic          in_left,
  input  logic [W-1:0]  in_opa,
  input  logic [W-1:0]  in_opb,
  input  logic [CW-1:0] in_count,
  output logic          s1_valid,
  output logic          s1_double,
  output logic          s1_left,
  output logic [W-1:0]  s1_opa,
  output logic [W-1:0]  s1_opb,
  output logic [CW-1:0] s1_count
);
  import shf_pkg::*;

  logic accept;

  // A single-length op issued now would finish together with a double-length
  // op that entered stage 1 on the previous edge.
  assign in_ready = !(s1_valid && (s1_double == OP_DOUBLE)) || (in_double == OP_DOUBLE);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_double <= 1'b0;
      s1_left   <= 1'b0;
      s1_opa    <= '0;
      s1_opb    <= '0;
      s1_count  <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_double <= in_double;
        s1_left   <= in_left;
        s1_opa    <= in_opa;
        s1_opb    <= in_opb;
        s1_count  <= in_count;
      end
    end
  end
endmodule

// File: rtl/shf_single_core.sv
// One-operand shift, purely combinational between stage 1 and the output register.
module shf_single_core #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  opa,
  input  logic          left,
  input  logic [CW-1:0] count,
  output logic [W-1:0]  res
);
  localparam int LB = $clog2(W);

  logic [W-1:0] moved;
  logic         too_far;

  shf_barrel #(.W(W), .NB(LB), .BASE(0)) u_bar (
    .din (opa),
    .left(left),
    .amt (count[LB-1:0]),
    .dout(moved)
  );

  assign too_far = |count[CW-1:LB];
  assign res     = too_far ? '0 : moved;
endmodule

// File: rtl/shf_double_core.sv
// Two-operand shift split over two cycles: coarse byte-scale moves, then fine moves.
module shf_double_core #(
  parameter int W    = 64,
  parameter int CW   = 7,
  parameter int FINE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          left,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [CW-1:0] count,
  output logic          dbl_valid,
  output logic [W-1:0]  dbl_res
);
  localparam int DW = 2 * W;
  localparam int CB = CW - FINE;

  logic [DW-1:0]   coarse;
  logic [DW-1:0]   d2_val;
  logic [FINE-1:0] d2_fine;
  logic            d2_left;
  logic            d2_valid;
  logic [DW-1:0]   fine_out;

  shf_barrel #(.W(DW), .NB(CB), .BASE(FINE)) u_coarse (
    .din ({opa, opb}),
    .left(left),
    .amt (count[CW-1:FINE]),
    .dout(coarse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d2_valid <= 1'b0;
      d2_left  <= 1'b0;
      d2_val   <= '0;
      d2_fine  <= '0;
    end else begin
      d2_valid <= in_valid;
      if (in_valid) begin
        d2_left <= left;
        d2_val  <= coarse;
        d2_fine <= count[FINE-1:0];
      end
    end
  end

  shf_barrel #(.W(DW), .NB(FINE), .BASE(0)) u_fine (
    .din (d2_val),
    .left(d2_left),
    .amt (d2_fine),
    .dout(fine_out)
  );

  assign dbl_valid = d2_valid;
  assign dbl_res   = d2_left ? fine_out[DW-1:W] : fine_out[W-1:0];
endmodule

// File: rtl/shf_out_merge.sv
// Output register fed by whichever path finishes this cycle.
module shf_out_merge #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sgl_valid,
  input  logic [W-1:0] sgl_res,
  input  logic         dbl_valid,
  input  logic [W-1:0] dbl_res,
  output logic         out_valid,
  output logic [W-1:0] out_result
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= sgl_valid || dbl_valid;
      if (dbl_valid)      out_result <= dbl_res;
      else if (sgl_valid) out_result <= sgl_res;
    end
  end

  // Both paths finishing together would lose a result.
  assert_one_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sgl_valid && dbl_valid));
endmodule

// File: rtl/dual_len_shifter.sv
module dual_len_shifter #(
  parameter int W    = 64,
  parameter int FINE = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_double,
  input  logic                     in_left,
  input  logic [W-1:0]             in_opa,
  input  logic [W-1:0]             in_opb,
  input  logic [$clog2(2*W)-1:0]   in_count,
  output logic                     out_valid,
  output logic [W-1:0]             out_result
);
  localparam int CW = $clog2(2 * W);

  logic          s1_valid, s1_double, s1_left;
  logic [W-1:0]  s1_opa, s1_opb;
  logic [CW-1:0] s1_count;
  logic [W-1:0]  sgl_res, dbl_res;
  logic          dbl_valid;

  shf_issue_ctl #(.W(W), .CW(CW)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_double(in_double),
    .in_left(in_left), .in_opa(in_opa), .in_opb(in_opb), .in_count(in_count),
    .s1_valid(s1_valid), .s1_double(s1_double), .s1_left(s1_left),
    .s1_opa(s1_opa), .s1_opb(s1_opb), .s1_count(s1_count)
  );

  shf_single_core #(.W(W), .CW(CW)) u_sgl (
    .opa(s1_opa), .left(s1_left), .count(s1_count), .res(sgl_res)
  );

  shf_double_core #(.W(W), .CW(CW), .FINE(FINE)) u_dbl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid && s1_double), .left(s1_left),
    .opa(s1_opa), .opb(s1_opb), .count(s1_count),
    .dbl_valid(dbl_valid), .dbl_res(dbl_res)
  );

  shf_out_merge #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .sgl_valid(s1_valid && !s1_double), .sgl_res(sgl_res),
    .dbl_valid(dbl_valid), .dbl_res(dbl_res),
    .out_valid(out_valid), .out_result(out_result)
  );

  // Issue history kept only for the checks below.
  logic acc_s, acc_d;
  logic [1:0] hist_s;
  logic [2:0] hist_d;
  assign acc_s = in_valid && in_ready && !in_double;
  assign acc_d = in_valid && in_ready && in_double;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_s <= '0;
      hist_d <= '0;
    end else begin
      hist_s <= {hist_s[0], acc_s};
      hist_d <= {hist_d[1:0], acc_d};
    end
  end

  assert_single_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hist_s[1] |-> out_valid);
  assert_double_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hist_d[2] |-> out_valid);
  assert_no_stray_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (hist_s[1] || hist_d[2]));
  assert_refuse_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (hist_d[0] && !in_double));
endmodule

// File: tb/sim_dual_len_shifter.sv
module sim_dual_len_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_double = 1'b0, in_left = 1'b0;
  logic [63:0] in_opa = '0, in_opb = '0;
  logic [6:0]  in_count = '0;
  logic        in_ready, out_valid;
  logic [63:0] out_result;

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  bit last_acc_d = 0;
  bit          exp_v [int];
  logic [63:0] exp_d [int];
  string       exp_t [int];

  always #5 clk = ~clk;

  dual_len_shifter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_double(in_double), .in_left(in_left), .in_opa(in_opa), .in_opb(in_opb),
    .in_count(in_count), .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [63:0] model(bit d, bit l, logic [63:0] a,
                                        logic [63:0] b, logic [6:0] c);
    logic [127:0] v;
    if (!d) begin
      if (c >= 64) return '0;
      return l ? (a << c) : (a >> c);
    end
    v = {a, b};
    if (l) begin v = v << c; return v[127:64]; end
    v = v >> c;
    return v[63:0];
  endfunction

  task automatic check_out();
    bit ev = exp_v.exists(n);
    checks++;
    if (out_valid !== ev) begin
      fails++;
      $display("FAIL %s cycle %0d out_valid actual %0b expected %0b",
               ev ? exp_t[n] : "R7", n, out_valid, ev);
    end else if (ev) begin
      checks++;
      if (out_result !== exp_d[n]) begin
        fails++;
        $display("FAIL %s cycle %0d out_result actual %h expected %h",
                 exp_t[n], n, out_result, exp_d[n]);
      end
    end
  endtask

  task automatic step(bit v, bit d, bit l, logic [63:0] a, logic [63:0] b, logic [6:0] c);
    bit rdy_exp;
    int due;
    @(negedge clk);
    n++;
    check_out();
    in_valid = v; in_double = d; in_left = l; in_opa = a; in_opb = b; in_count = c;
    #1;
    rdy_exp = !last_acc_d || d;
    checks++;
    if (in_ready !== rdy_exp) begin
      fails++;
      $display("FAIL R6 cycle %0d in_ready actual %0b expected %0b", n, in_ready, rdy_exp);
    end
    last_acc_d = v && rdy_exp && d;
    if (v && rdy_exp) begin
      due = n + (d ? 3 : 2);
      exp_v[due] = 1;
      exp_d[due] = model(d, l, a, b, c);
      if (c == 0) exp_t[due] = "R5";
      else if (d) exp_t[due] = l ? "R3" : "R4";
      else        exp_t[due] = l ? "R1" : "R2";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: state right after reset
    checks += 2;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R8 out_valid actual %0b expected 0", out_valid); end
    if (in_ready !== 1'b1) begin fails++; $display("FAIL R8 in_ready actual %0b expected 1", in_ready); end

    // Single-length, both directions, boundary counts; opb set to junk (R1/R2: ignored)
    step(1, 0, 1, 64'h8000_0000_0000_0001, '1, 7'd0);
    step(1, 0, 1, 64'h8000_0000_0000_0001, '1, 7'd1);
    step(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, '1, 7'd63);
    step(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, '1, 7'd64);
    step(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, '1, 7'd127);
    step(1, 0, 0, 64'h8000_0000_0000_0001, '1, 7'd0);
    step(1, 0, 0, 64'h8000_0000_0000_0001, '1, 7'd1);
    step(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, '1, 7'd63);
    step(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, '1, 7'd64);
    // Double-length, both directions
    step(1, 1, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd0);
    step(1, 1, 0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd0);
    step(1, 1, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd4);
    step(1, 1, 0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd4);
    step(1, 1, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd64);
    step(1, 1, 0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd64);
    step(1, 1, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd127);
    step(1, 1, 0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 7'd127);
    step(1, 1, 1, 64'hAAAA_5555_AAAA_5555, 64'h1234_0000_0000_9999, 7'd37);
    // R6: single right after a double is refused; held and re-offered
    step(1, 0, 1, 64'hDEAD_BEEF_0000_1111, '0, 7'd8);
    step(1, 0, 1, 64'hDEAD_BEEF_0000_1111, '0, 7'd8);
    step(0, 0, 0, '0, '0, 7'd0);
    // Single then double back to back, order kept (R7)
    step(1, 0, 0, 64'hF0F0_F0F0_F0F0_F0F0, '0, 7'd12);
    step(1, 1, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 7'd99);
    step(1, 1, 1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 7'd70);
    step(1, 0, 0, 64'h1, '0, 7'd0);
    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 7, $urandom % 2, $urandom % 2,
           {$urandom, $urandom}, {$urandom, $urandom}, 7'($urandom));
    end
    for (int i = 0; i < 6; i++) step(0, 0, 0, '0, '0, 7'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", n);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule